// File: doc/BRIEF.md
# Power Mode Transition Sequencer

This block steps a processor straight from its slow subactive mode into full-speed active mode. A sleep request starts the sequence. First a short fixed interval is timed on the subclock, which is the watch-clock strobe divided down by a selectable ratio. The clock source is then switched to the chosen fast clock. Two waits follow on that new clock: a programmable oscillator settling interval, then a fixed interval for interrupt exception handling. The core is held until both have elapsed, and a completion pulse marks its release.

All clocks are modelled as enable strobes inside one system clock domain. The watch clock, the main oscillator and the on-chip oscillator each arrive as a single-cycle tick input. A small control register selects three things: the subclock ratio, the target clock and a 3-bit settling-length code. That register is locked while a transition runs.

A separate bank of module-standby bits produces one clock enable per peripheral. Setting a bit to 1 stops that peripheral's clock; clearing it restores the clock.

Top module: `pwr_xition_seq`

## Requirements
- R1: After reset `busy` and `done` are 0, `clk_src` is 2'b00 (subclock) and every bit of `mod_clk_en` is 1.
- R2: A `sleep_req` sampled while idle makes `busy` 1 from the next cycle on. `busy` stays 1 until the cycle in which `done` is raised.
- R3: The pre-switch phase lasts exactly 3 subclock periods. With `cfg_wdata[3]`=0 the subclock is the watch tick divided by 8, so the phase is 24 watch ticks. With `cfg_wdata[3]`=1 it is divided by 4, so the phase is 12 watch ticks. The subclock divider restarts at the accepted request.
- R4: The settling code is `cfg_wdata[2:0]`. Codes 0 to 5 give 2^(SETTLE_MIN_LOG2+code) new-clock ticks. Codes 6 and 7 fall back to the longest count, 2^(SETTLE_MIN_LOG2+5). With the default SETTLE_MIN_LOG2=10 the counts run from 1024 to 32768, including 4096 (code 2).
- R5: After the settling wait, exactly 16 more new-clock ticks pass for exception handling before the core is released.
- R6: `cfg_wdata[4]` selects the target clock: 0 is the main oscillator tick, 1 is the on-chip oscillator tick divided by 2. `clk_src` changes to 2'b01 or 2'b10 respectively when the pre-switch phase ends, stays there until reset, and spends one switch cycle before settling starts.
- R7: `done` is a single-cycle pulse raised on entry to the active state. In that cycle `busy` is already 0.
- R8: A `sleep_req` while a transition runs, or after the active state is reached, is ignored. The running transition keeps its length, and `busy` stays 0 once active.
- R9: A control-register write (`cfg_we`) while `busy` is 1 is ignored. The running transition keeps the settings latched before it began.
- R10: When `mstby_we` is 1, `mod_clk_en` becomes the inverse of `mstby_wdata` from the next cycle: a 1 bit stops that peripheral's clock, and a 0 bit restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| watch_tick | input | 1 | Watch-clock enable strobe |
| osc_tick | input | 1 | Main oscillator enable strobe |
| rosc_tick | input | 1 | On-chip oscillator enable strobe |
| sleep_req | input | 1 | Start a direct transition |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | {target select, subclock ratio, settling code[2:0]} |
| mstby_we | input | 1 | Module-standby register write strobe |
| mstby_wdata | input | N_MOD | Module-standby bits, 1 stops that module |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle pulse on reaching active mode |
| clk_src | output | 2 | Selected clock: 00 subclock, 01 oscillator, 10 on-chip oscillator/2 |
| mod_clk_en | output | N_MOD | Per-module clock enables |

## Verification
The bench builds the block with SETTLE_MIN_LOG2=2, which scales the settling counts to 4 through 128 ticks. Every code, including the two fallback codes, then completes in a few hundred cycles. This brings both target clocks, both subclock ratios and the in-flight request and configuration writes within reach in one short run. N_MOD=4 keeps the standby bank small while still exercising a mixed bit pattern.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SUB    = 3'd1,
        ST_SWITCH = 3'd2,
        ST_SETTLE = 3'd3,
        ST_EXC    = 3'd4,
        ST_ACTIVE = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_SUB   = 2'b00,
        SRC_OSC   = 2'b01,
        SRC_ROSC2 = 2'b10
    } clk_src_e;

    typedef struct packed {
        logic       tgt_rosc;
        logic       sub_div4;
        logic [2:0] settle_code;
    } seq_cfg_t;

    localparam int CFG_W        = $bits(seq_cfg_t);
    localparam int MAX_CODE_EXP = 5;

    function automatic int unsigned settle_exp(input logic [2:0] code);
        if (code > 3'(MAX_CODE_EXP))
            return MAX_CODE_EXP;
        return int'(code);
    endfunction

    function automatic int unsigned settle_len(input logic [2:0] code,
                                               input int unsigned min_log2);
        return 32'd1 << (min_log2 + settle_exp(code));
    endfunction

endpackage

// File: rtl/pxs_sub_div.sv
module pxs_sub_div (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic watch_tick,
    input  logic div4,
    output logic sub_tick
);
    logic [2:0] cnt_q;
    logic [2:0] last;

    assign last     = div4 ? 3'd3 : 3'd7;
    assign sub_tick = !clr && watch_tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (watch_tick)
            cnt_q <= (cnt_q == last) ? 3'd0 : cnt_q + 3'd1;
    end
endmodule

// File: rtl/pxs_tgt_tick.sv
module pxs_tgt_tick (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sel_rosc,
    input  logic osc_tick,
    input  logic rosc_tick,
    output logic new_tick
);
    logic half_q;

    always_comb begin
        if (clr)
            new_tick = 1'b0;
        else if (sel_rosc)
            new_tick = rosc_tick && half_q;
        else
            new_tick = osc_tick;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            half_q <= 1'b0;
        else if (sel_rosc && rosc_tick)
            half_q <= !half_q;
    end
endmodule

// File: rtl/pxs_seq_fsm.sv
module pxs_seq_fsm
    import pxs_pkg::*;
#(
    parameter int SETTLE_MIN_LOG2 = 10,
    parameter int SUB_CYCLES      = 3,
    parameter int EXC_CYCLES      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       sub_tick,
    input  logic       new_tick,
    input  seq_cfg_t   cfg,
    output seq_state_e state,
    output logic       busy,
    output logic       done,
    output logic [1:0] clk_src,
    output logic       sub_clr,
    output logic       tgt_clr
);
    localparam int CNT_W = SETTLE_MIN_LOG2 + MAX_CODE_EXP + 1;
    localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(SUB_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXC_LAST = CNT_W'(EXC_CYCLES - 1);

    seq_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    clk_src_e        src_q, src_d;
    logic            done_q, done_d;
    logic [CNT_W-1:0] settle_last;

    assign settle_last =
        CNT_W'(settle_len(cfg.settle_code, SETTLE_MIN_LOG2) - 32'd1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        src_d   = src_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (sleep_req)
                    state_d = ST_SUB;
            end
            ST_SUB: begin
                if (sub_tick) begin
                    if (cnt_q == SUB_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_SWITCH;
                        src_d   = cfg.tgt_rosc ? SRC_ROSC2 : SRC_OSC;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SWITCH: begin
                cnt_d   = '0;
                state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (new_tick) begin
                    if (cnt_q == settle_last) begin
                        cnt_d   = '0;
                        state_d = ST_EXC;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_EXC: begin
                if (new_tick) begin
                    if (cnt_q == EXC_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_ACTIVE;
                        done_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_ACTIVE: begin
                cnt_d = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            src_q   <= SRC_SUB;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            src_q   <= src_d;
            done_q  <= done_d;
        end
    end

    assign state   = state_q;
    assign busy    = (state_q == ST_SUB) || (state_q == ST_SWITCH) ||
                     (state_q == ST_SETTLE) || (state_q == ST_EXC);
    assign done    = done_q;
    assign clk_src = src_q;
    assign sub_clr = (state_q != ST_SUB);
    assign tgt_clr = (state_q != ST_SETTLE) && (state_q != ST_EXC);
endmodule

// File: rtl/pxs_standby.sv
module pxs_standby #(
    parameter int N_MOD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [N_MOD-1:0] wdata,
    output logic [N_MOD-1:0] clk_en
);
    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
        logic stop_q;
        always_ff @(posedge clk) begin
            if (rst)
                stop_q <= 1'b0;
            else if (we)
                stop_q <= wdata[i];
        end
        assign clk_en[i] = !stop_q;
    end
endmodule

// File: rtl/pwr_xition_seq.sv
module pwr_xition_seq
    import pxs_pkg::*;
#(
    parameter int N_MOD           = 8,
    parameter int SETTLE_MIN_LOG2 = 10,
    parameter int SUB_CYCLES      = 3,
    parameter int EXC_CYCLES      = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 watch_tick,
    input  logic                 osc_tick,
    input  logic                 rosc_tick,
    input  logic                 sleep_req,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 mstby_we,
    input  logic [N_MOD-1:0]     mstby_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           clk_src,
    output logic [N_MOD-1:0]     mod_clk_en
);
    seq_cfg_t   cfg_q;
    seq_state_e state;
    logic       sub_tick, new_tick, sub_clr, tgt_clr;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we && !busy)
            cfg_q <= seq_cfg_t'(cfg_wdata);
    end

    pxs_sub_div u_sub_div (
        .clk        (clk),
        .rst        (rst),
        .clr        (sub_clr),
        .watch_tick (watch_tick),
        .div4       (cfg_q.sub_div4),
        .sub_tick   (sub_tick)
    );

    pxs_tgt_tick u_tgt_tick (
        .clk       (clk),
        .rst       (rst),
        .clr       (tgt_clr),
        .sel_rosc  (cfg_q.tgt_rosc),
        .osc_tick  (osc_tick),
        .rosc_tick (rosc_tick),
        .new_tick  (new_tick)
    );

    pxs_seq_fsm #(
        .SETTLE_MIN_LOG2 (SETTLE_MIN_LOG2),
        .SUB_CYCLES      (SUB_CYCLES),
        .EXC_CYCLES      (EXC_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .sub_tick  (sub_tick),
        .new_tick  (new_tick),
        .cfg       (cfg_q),
        .state     (state),
        .busy      (busy),
        .done      (done),
        .clk_src   (clk_src),
        .sub_clr   (sub_clr),
        .tgt_clr   (tgt_clr)
    );

    pxs_standby #(.N_MOD(N_MOD)) u_standby (
        .clk    (clk),
        .rst    (rst),
        .we     (mstby_we),
        .wdata  (mstby_wdata),
        .clk_en (mod_clk_en)
    );

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/pwr_xition_seq_chk.sv
module pwr_xition_seq_chk #(
    parameter int N_MOD = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       cfg_q,
    input logic             mstby_we,
    input logic [N_MOD-1:0] mstby_wdata,
    input logic             busy,
    input logic             done,
    input logic [1:0]       clk_src,
    input logic [N_MOD-1:0] mod_clk_en
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_src != 2'b00) |=> $stable(clk_src));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    // R8
    active_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && clk_src != 2'b00) |=> !busy);

    // R10
    standby_chk: assert property (@(posedge clk) disable iff (rst)
        mstby_we |=> (mod_clk_en == ~$past(mstby_wdata)));
endmodule

bind pwr_xition_seq pwr_xition_seq_chk #(.N_MOD(N_MOD)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_q       (cfg_q),
    .mstby_we    (mstby_we),
    .mstby_wdata (mstby_wdata),
    .busy        (busy),
    .done        (done),
    .clk_src     (clk_src),
    .mod_clk_en  (mod_clk_en)
);

// File: tb/test_pwr_xition_seq.sv
`timescale 1ns/1ps
module test_pwr_xition_seq;
    localparam int N_MOD   = 4;
    localparam int MIN_LOG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic watch_tick = 1'b0;
    logic osc_tick = 1'b1;
    logic rosc_tick = 1'b1;
    logic sleep_req = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic mstby_we = 1'b0;
    logic [N_MOD-1:0] mstby_wdata = '0;
    logic busy, done;
    logic [1:0] clk_src;
    logic [N_MOD-1:0] mod_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    int tot_sub = 0;
    int tot_new = 0;
    int tot_done = 0;
    int cyc = 0;
    logic wt_phase = 1'b0;

    pwr_xition_seq #(.N_MOD(N_MOD), .SETTLE_MIN_LOG2(MIN_LOG)) i_pwr_xition_seq (
        .clk(clk), .rst(rst), .watch_tick(watch_tick), .osc_tick(osc_tick),
        .rosc_tick(rosc_tick), .sleep_req(sleep_req), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .mstby_we(mstby_we), .mstby_wdata(mstby_wdata),
        .busy(busy), .done(done), .clk_src(clk_src), .mod_clk_en(mod_clk_en)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        wt_phase   = !wt_phase;
        watch_tick = wt_phase;
        if (busy && clk_src == 2'b00) tot_sub += int'(watch_tick);
        if (busy && clk_src != 2'b00) tot_new += 1;
        if (done) tot_done += 1;
        cyc += 1;
        if (cyc > 150000) begin
            n_chk += 1;
            n_bad += 1;
            $display("FAIL watchdog: act cyc=%0d exp finish", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk += 1;
        if (!ok) begin
            n_bad += 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    function automatic int exp_settle(input int code);
        return 1 << (MIN_LOG + ((code > 5) ? 5 : code));
    endfunction

    // one full transition; inject=1 pulses sleep_req and a cfg write mid-run
    task automatic run_xition(input bit div4, input bit rosc, input int code,
                              input bit inject, input string tag);
        int s_sub, s_new, s_done, k, exp_new;
        bit seen;
        do_reset();
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {rosc, div4, 3'(code)};
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        s_sub = tot_sub; s_new = tot_new; s_done = tot_done;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        // R2: busy seen in the cycle after the request edge
        chk(busy == 1'b1, {tag, " R2 busy after request"}, int'(busy), 1);
        seen = 0;
        for (int i = 0; i < 2000; i++) begin
            if (inject && i == 40) begin
                sleep_req = 1'b1;
                cfg_we = 1'b1;
                cfg_wdata = {!rosc, !div4, 3'd0};
            end else begin
                sleep_req = 1'b0;
                cfg_we = 1'b0;
            end
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        sleep_req = 1'b0;
        cfg_we = 1'b0;
        chk(seen, {tag, " R7 done reached"}, int'(seen), 1);
        // R7: busy already low in the done cycle
        chk(busy == 1'b0, {tag, " R7 busy low at done"}, int'(busy), 0);
        repeat (3) @(negedge clk);
        #1;
        k = rosc ? 2 : 1;
        exp_new = 1 + k * (exp_settle(code) + 16);
        // R3: 3 subclock periods of watch ticks
        chk((tot_sub - s_sub) == 3 * (div4 ? 4 : 8), {tag, " R3 sub phase watch ticks"},
            tot_sub - s_sub, 3 * (div4 ? 4 : 8));
        // R4 R5: switch + settle + 16 exception ticks on new clock
        chk((tot_new - s_new) == exp_new, {tag, " R4 R5 new-clock cycles"},
            tot_new - s_new, exp_new);
        // R6
        chk(clk_src == (rosc ? 2'b10 : 2'b01), {tag, " R6 clk_src"},
            int'(clk_src), rosc ? 2 : 1);
        // R7 single pulse
        chk((tot_done - s_done) == 1, {tag, " R7 done width"}, tot_done - s_done, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(clk_src == 2'b00, "R1 clk_src", int'(clk_src), 0);
        chk(mod_clk_en == '1, "R1 mod_clk_en", int'(mod_clk_en), 15);
    endtask

    task automatic t_active_ignore();
        int s_new;
        // R8: request after reaching active mode
        s_new = tot_new;
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        for (int i = 0; i < 30; i++) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R8 active request busy", int'(busy), 0);
        chk(tot_new == s_new, "R8 active request no activity", tot_new - s_new, 0);
    endtask

    task automatic t_standby();
        do_reset();
        @(negedge clk);
        mstby_we = 1'b1;
        mstby_wdata = 4'b1010;
        @(negedge clk);
        mstby_we = 1'b0;
        mstby_wdata = 4'b0000;
        chk(mod_clk_en == 4'b0101, "R10 stop modules", int'(mod_clk_en), 5);
        repeat (2) @(negedge clk);
        chk(mod_clk_en == 4'b0101, "R10 hold without write", int'(mod_clk_en), 5);
        mstby_we = 1'b1;
        mstby_wdata = 4'b0000;
        @(negedge clk);
        mstby_we = 1'b0;
        chk(mod_clk_en == 4'b1111, "R10 restore modules", int'(mod_clk_en), 15);
    endtask

    initial begin
        t_reset();
        run_xition(1'b0, 1'b0, 2, 1'b0, "osc_div8_c2");
        run_xition(1'b1, 1'b1, 0, 1'b0, "rosc_div4_c0");
        run_xition(1'b0, 1'b0, 7, 1'b0, "R4 fallback_c7");
        run_xition(1'b0, 1'b1, 6, 1'b0, "R4 fallback_c6");
        run_xition(1'b0, 1'b0, 5, 1'b0, "R4 longest_c5");
        // R8 R9: request and cfg write injected mid-transition
        run_xition(1'b1, 1'b0, 3, 1'b1, "R8 R9 inject_c3");
        t_active_ignore();
        t_standby();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule